// File: doc/BRIEF.md
# Deferred Load Fault Tracker

This block keeps the fault state of speculative loads that must not trap. For every load it is handed, it adds the base value and the offset to form the effective address. It then checks that address, and the destination register number, against the alignment the access size needs. A fault does not trap. It sets a per-register deferred-fault flag on the destination. The flag travels from source to destination: a clean load whose base register, or whose index register when one is used, carries a flag passes that flag to its destination and is told not to access memory.

When the logging switches are on, each load also writes a status word and its effective address into the lowest free slot of a small log table. A later commit on a register reports a commit exception if that register's flag was set and logging is on. The commit always clears the flag, and it also zeroes the log slots that belong to that register. A commit can also cover all registers, limited to the halves the caller marks as available. General and floating registers each have their own flag bank.

Top module: `nel_tracker`

## Requirements
- R1: Size codes are 0 byte, 1 half, 2 word, 3 double, 4 quad; codes 5 to 7 behave as byte. `ld_addr_fault` is set when the effective address (`ld_base_val + ld_off_val`) has a nonzero value in the low bits for the size: bit 0 for half, bits 1:0 for word, bits 2:0 for double, bits 3:0 for quad. A byte load never faults.
- R2: `ld_reg_fault` is set for a double load with an odd destination, and for a quad load whose destination is not a multiple of 4.
- R3: Flags are kept in two banks selected by `ld_float` / `cm_float`: bank 0 is general (`gr_flags`), bank 1 is floating (`fr_flags`). The base and index flags are read from the bank of the load. An operation leaves the other bank unchanged.
- R4: On an address or register fault, the destination flag is set and `ld_go` stays 1.
- R5: On a load without fault, the destination flag is set and `ld_go` is 0 when the base flag is set, or when `ld_use_idx` is 1 and the index flag is set. Otherwise the destination flag is cleared and `ld_go` is 1.
- R6: Logging is on only when `cfg_valid` and `cfg_log_en` are both 1. With logging on, each load fills the lowest-index invalid slot below `cfg_count`. The slot's status bits are: [15] valid, [14] address valid, [13] floating, [12] register fault, [11] address fault, [10:8] size, [7:6] own slot index, [5:0] destination. The slot's address holds the effective address. Both are read through `rd_sel`.
- R7: A single commit clears the flag of `cm_dst`. If logging is on and that flag was set, `cm_exc` is 1 and every valid slot of the same kind with that destination is zeroed; otherwise `cm_exc` is 0 and the table is unchanged.
- R8: With `cm_all` set, the commit counts as flagged if any flag of the kind is set in an available half (low half = registers 0 to NREG/2-1 with `cm_avail_lo`, high half with `cm_avail_hi`). Only the available halves are cleared, and every valid slot of that kind is zeroed when an exception is raised.
- R9: When logging is on and no free slot exists below `cfg_count`, `ld_log_full` is 1 and the table is not written. The flag update still happens.
- R10: Every result (`ld_done`, `ld_go`, `ld_addr_fault`, `ld_reg_fault`, `ld_log_full`, `cm_done`, `cm_exc`, the flag vectors and the table) appears one clock after the operation is presented. After reset all flags, outputs and slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Control word valid |
| cfg_log_en | input | 1 | Log enable |
| cfg_count | input | 3 | Number of implemented log slots |
| ld_valid | input | 1 | Load presented this cycle |
| ld_float | input | 1 | Load targets the floating bank |
| ld_size | input | 3 | Access size code |
| ld_dst | input | 6 | Destination register |
| ld_base | input | 6 | Base register number |
| ld_use_idx | input | 1 | An index register supplies the offset |
| ld_idx | input | 6 | Index register number |
| ld_base_val | input | 32 | Base register value |
| ld_off_val | input | 32 | Index value or immediate offset |
| cm_valid | input | 1 | Commit presented this cycle |
| cm_float | input | 1 | Commit targets the floating bank |
| cm_all | input | 1 | Commit covers all registers |
| cm_dst | input | 6 | Register to commit |
| cm_avail_lo | input | 1 | Low half available for an all-commit |
| cm_avail_hi | input | 1 | High half available for an all-commit |
| rd_sel | input | 2 | Log slot to read |
| ld_done | output | 1 | Load result valid |
| ld_go | output | 1 | Memory access may proceed |
| ld_addr_fault | output | 1 | Address misalignment detected |
| ld_reg_fault | output | 1 | Register misalignment detected |
| ld_log_full | output | 1 | No free log slot |
| cm_done | output | 1 | Commit result valid |
| cm_exc | output | 1 | Commit exception |
| gr_flags | output | 64 | General bank flags |
| fr_flags | output | 64 | Floating bank flags |
| rd_status | output | 16 | Status word of selected slot |
| rd_addr | output | 32 | Address of selected slot |

## Verification
Each load or commit is applied for one cycle, and its result is due exactly one clock later. The flag vectors and the table change on that same edge. The driver sets inputs on a falling edge and pushes the expected item at once. The monitor pops it on the next falling edge, where `ld_done` or `cm_done` is high, and compares the result pins and both flag vectors. The table read port is combinational, so it is read between operations, a few time units after a falling edge.

// File: rtl/nel_pkg.sv
package nel_pkg;

    localparam int REG_IDX_W = 6;
    localparam int ENT_IDX_W = 2;
    localparam int ADDR_W    = 32;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DBL  = 3'd3,
        SZ_QUAD = 3'd4
    } size_e;

    typedef struct packed {
        logic                 valid;
        logic                 addr_ok;
        logic                 is_fp;
        logic                 reg_mis;
        logic                 addr_mis;
        logic [2:0]           size;
        logic [ENT_IDX_W-1:0] slot;
        logic [REG_IDX_W-1:0] drn;
    } log_ent_t;

    function automatic logic addr_misaligned(input logic [2:0] sz, input logic [3:0] lsb);
        case (sz)
            SZ_HALF: return lsb[0];
            SZ_WORD: return |lsb[1:0];
            SZ_DBL:  return |lsb[2:0];
            SZ_QUAD: return |lsb[3:0];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic reg_misaligned(input logic [2:0] sz, input logic [1:0] dlsb);
        case (sz)
            SZ_DBL:  return dlsb[0];
            SZ_QUAD: return |dlsb;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/nel_fault_check.sv
module nel_fault_check
    import nel_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int RW = REG_IDX_W
) (
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] off_val,
    input  logic [2:0]    size,
    input  logic [RW-1:0] dst,
    output logic [AW-1:0] ea,
    output logic          addr_mis,
    output logic          reg_mis
);
    always_comb begin
        ea       = base_val + off_val;
        addr_mis = addr_misaligned(size, ea[3:0]);
        reg_mis  = reg_misaligned(size, dst[1:0]);
    end
endmodule

// File: rtl/nel_flag_bank.sv
module nel_flag_bank #(
    parameter int NREG = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    set_en,
    input  logic [$clog2(NREG)-1:0] set_idx,
    input  logic                    set_val,
    input  logic                    clr_en,
    input  logic [$clog2(NREG)-1:0] clr_idx,
    input  logic                    clr_lo,
    input  logic                    clr_hi,
    output logic [NREG-1:0]         flags
);
    localparam int HALF = NREG / 2;

    logic [NREG-1:0] nxt;

    always_comb begin
        nxt = flags;
        if (set_en) nxt[set_idx] = set_val;
        if (clr_en) nxt[clr_idx] = 1'b0;
        if (clr_lo) nxt[HALF-1:0] = '0;
        if (clr_hi) nxt[NREG-1:HALF] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    // R5
    flag_write_chk: assert property (@(posedge clk) disable iff (rst)
        set_en && !clr_en && !clr_lo && !clr_hi |=> flags[$past(set_idx)] == $past(set_val));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !flags[$past(clr_idx)]);

    // R8
    half_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_lo |=> flags[HALF-1:0] == '0);
endmodule

// File: rtl/nel_log_table.sv
module nel_log_table
    import nel_pkg::*;
#(
    parameter int NENT = 1 << ENT_IDX_W,
    parameter int AW   = ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(NENT+1)-1:0]  cnt,
    input  logic                       wr_req,
    input  log_ent_t                   wr_ent,
    input  logic [AW-1:0]              wr_addr,
    input  logic                       clr_req,
    input  logic                       clr_fp,
    input  logic                       clr_all,
    input  logic [REG_IDX_W-1:0]       clr_drn,
    input  logic [$clog2(NENT)-1:0]    rd_sel,
    output logic                       full,
    output log_ent_t                   rd_ent,
    output logic [AW-1:0]              rd_addr
);
    localparam int EW = $clog2(NENT);

    log_ent_t        ent_q  [NENT];
    logic [AW-1:0]   addr_q [NENT];
    logic [EW-1:0]   pick;
    logic            found;
    logic [NENT-1:0] vld;
    logic [NENT-1:0] hit;
    log_ent_t        fill;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NENT; i++) begin
            vld[i] = ent_q[i].valid;
            hit[i] = ent_q[i].valid && (ent_q[i].is_fp == clr_fp)
                     && (clr_all || ent_q[i].drn == clr_drn);
            if (!found && (i < int'(cnt)) && !ent_q[i].valid) begin
                found = 1'b1;
                pick  = EW'(i);
            end
        end
        full      = !found;
        fill      = wr_ent;
        fill.slot = ENT_IDX_W'(pick);
        rd_ent    = ent_q[rd_sel];
        rd_addr   = addr_q[rd_sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) begin
                ent_q[i]  <= '0;
                addr_q[i] <= '0;
            end
        end else if (wr_req && found) begin
            ent_q[pick]  <= fill;
            addr_q[pick] <= wr_addr;
        end else if (clr_req) begin
            for (int i = 0; i < NENT; i++) begin
                if (hit[i]) begin
                    ent_q[i]  <= '0;
                    addr_q[i] <= '0;
                end
            end
        end
    end

    // R6
    slot_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && !full |=> $countones(vld) == $past($countones(vld)) + 1);

    // R9
    table_full_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req && full |=> $stable(vld));
endmodule

// File: rtl/nel_tracker.sv
module nel_tracker
    import nel_pkg::*;
#(
    parameter int NREG = 1 << REG_IDX_W,
    parameter int NENT = 1 << ENT_IDX_W,
    parameter int AW   = ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_valid,
    input  logic                       cfg_log_en,
    input  logic [$clog2(NENT+1)-1:0]  cfg_count,
    input  logic                       ld_valid,
    input  logic                       ld_float,
    input  logic [2:0]                 ld_size,
    input  logic [$clog2(NREG)-1:0]    ld_dst,
    input  logic [$clog2(NREG)-1:0]    ld_base,
    input  logic                       ld_use_idx,
    input  logic [$clog2(NREG)-1:0]    ld_idx,
    input  logic [AW-1:0]              ld_base_val,
    input  logic [AW-1:0]              ld_off_val,
    input  logic                       cm_valid,
    input  logic                       cm_float,
    input  logic                       cm_all,
    input  logic [$clog2(NREG)-1:0]    cm_dst,
    input  logic                       cm_avail_lo,
    input  logic                       cm_avail_hi,
    input  logic [$clog2(NENT)-1:0]    rd_sel,
    output logic                       ld_done,
    output logic                       ld_go,
    output logic                       ld_addr_fault,
    output logic                       ld_reg_fault,
    output logic                       ld_log_full,
    output logic                       cm_done,
    output logic                       cm_exc,
    output logic [NREG-1:0]            gr_flags,
    output logic [NREG-1:0]            fr_flags,
    output logic [$bits(log_ent_t)-1:0] rd_status,
    output logic [AW-1:0]              rd_addr
);
    localparam int RW   = $clog2(NREG);
    localparam int HALF = NREG / 2;

    logic [NREG-1:0] bank_flags [2];
    logic [AW-1:0]   ea;
    logic            a_mis, r_mis, fault, prop, new_flag, log_on;
    logic [NREG-1:0] ld_fl, cm_fl;
    logic            cm_was;
    logic            tab_full;
    log_ent_t        wr_ent, rd_ent;

    nel_fault_check #(.AW(AW), .RW(RW)) u_chk (
        .base_val (ld_base_val),
        .off_val  (ld_off_val),
        .size     (ld_size),
        .dst      (ld_dst),
        .ea       (ea),
        .addr_mis (a_mis),
        .reg_mis  (r_mis)
    );

    always_comb begin
        log_on   = cfg_valid && cfg_log_en;
        fault    = a_mis || r_mis;
        ld_fl    = ld_float ? bank_flags[1] : bank_flags[0];
        prop     = ld_fl[ld_base] || (ld_use_idx && ld_fl[ld_idx]);
        new_flag = fault || prop;
        cm_fl    = cm_float ? bank_flags[1] : bank_flags[0];
        if (cm_all)
            cm_was = (cm_avail_hi && |cm_fl[NREG-1:HALF]) || (cm_avail_lo && |cm_fl[HALF-1:0]);
        else
            cm_was = cm_fl[cm_dst];
        wr_ent          = '0;
        wr_ent.valid    = 1'b1;
        wr_ent.addr_ok  = 1'b1;
        wr_ent.is_fp    = ld_float;
        wr_ent.reg_mis  = r_mis;
        wr_ent.addr_mis = a_mis;
        wr_ent.size     = ld_size;
        wr_ent.drn      = REG_IDX_W'(ld_dst);
    end

    for (genvar k = 0; k < 2; k++) begin : g_bank
        logic mine_ld, mine_cm;
        assign mine_ld = ld_valid && (ld_float == (k == 1));
        assign mine_cm = cm_valid && (cm_float == (k == 1));
        nel_flag_bank #(.NREG(NREG)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_en  (mine_ld),
            .set_idx (ld_dst),
            .set_val (new_flag),
            .clr_en  (mine_cm && !cm_all),
            .clr_idx (cm_dst),
            .clr_lo  (mine_cm && cm_all && cm_avail_lo),
            .clr_hi  (mine_cm && cm_all && cm_avail_hi),
            .flags   (bank_flags[k])
        );
    end

    nel_log_table #(.NENT(NENT), .AW(AW)) u_tab (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cfg_count),
        .wr_req  (ld_valid && log_on),
        .wr_ent  (wr_ent),
        .wr_addr (ea),
        .clr_req (cm_valid && log_on && cm_was),
        .clr_fp  (cm_float),
        .clr_all (cm_all),
        .clr_drn (REG_IDX_W'(cm_dst)),
        .rd_sel  (rd_sel),
        .full    (tab_full),
        .rd_ent  (rd_ent),
        .rd_addr (rd_addr)
    );

    assign gr_flags  = bank_flags[0];
    assign fr_flags  = bank_flags[1];
    assign rd_status = rd_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_done       <= 1'b0;
            ld_go         <= 1'b0;
            ld_addr_fault <= 1'b0;
            ld_reg_fault  <= 1'b0;
            ld_log_full   <= 1'b0;
            cm_done       <= 1'b0;
            cm_exc        <= 1'b0;
        end else begin
            ld_done       <= ld_valid;
            ld_go         <= ld_valid && (fault || !prop);
            ld_addr_fault <= ld_valid && a_mis;
            ld_reg_fault  <= ld_valid && r_mis;
            ld_log_full   <= ld_valid && log_on && tab_full;
            cm_done       <= cm_valid;
            cm_exc        <= cm_valid && log_on && cm_was;
        end
    end

    // R4
    go_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        ld_done && (ld_addr_fault || ld_reg_fault) |-> ld_go);

    // R1
    byte_never_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid && ld_size == 3'd0 |=> !ld_addr_fault);

    // R3
    other_bank_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid && !ld_float && !cm_valid |=> $stable(fr_flags));

    // R9
    full_with_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_log_full |-> ld_done);

    // R7
    exc_needs_log_chk: assert property (@(posedge clk) disable iff (rst)
        cm_valid && !(cfg_valid && cfg_log_en) |=> !cm_exc);
endmodule

// File: tb/sim_nel_tracker.sv
module sim_nel_tracker;
    localparam int CLK_P = 10;

    typedef struct {
        bit          is_cm;
        bit          go, af, rf, full, exc;
        logic [63:0] gr, fr;
        string       tag;
    } exp_t;

    logic clk = 0, rst = 1;
    logic cfg_valid = 1, cfg_log_en = 0;
    logic [2:0] cfg_count = 3'd4;
    logic ld_valid = 0, ld_float = 0, ld_use_idx = 0;
    logic [2:0] ld_size = 0;
    logic [5:0] ld_dst = 0, ld_base = 0, ld_idx = 0, cm_dst = 0;
    logic [31:0] ld_base_val = 0, ld_off_val = 0;
    logic cm_valid = 0, cm_float = 0, cm_all = 0, cm_avail_lo = 0, cm_avail_hi = 0;
    logic [1:0] rd_sel = 0;
    logic ld_done, ld_go, ld_addr_fault, ld_reg_fault, ld_log_full, cm_done, cm_exc;
    logic [63:0] gr_flags, fr_flags;
    logic [15:0] rd_status;
    logic [31:0] rd_addr;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    exp_t sbq[$];
    logic [63:0] m_gr = '0, m_fr = '0;
    bit          m_val [4];
    logic [15:0] m_st  [4];
    logic [31:0] m_ad  [4];

    nel_tracker u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && (ld_done || cm_done)) begin
            if (sbq.size() == 0) begin
                check(0, "R10", "unexpected result", 64'(ld_done), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(ld_done == !e.is_cm && cm_done == e.is_cm, e.tag, "done kind",
                      64'({ld_done, cm_done}), 64'({!e.is_cm, e.is_cm}));
                if (!e.is_cm) begin
                    check(ld_go == e.go, e.tag, "go", 64'(ld_go), 64'(e.go));
                    check(ld_addr_fault == e.af, e.tag, "addr fault", 64'(ld_addr_fault), 64'(e.af));
                    check(ld_reg_fault == e.rf, e.tag, "reg fault", 64'(ld_reg_fault), 64'(e.rf));
                    check(ld_log_full == e.full, e.tag, "log full", 64'(ld_log_full), 64'(e.full));
                end else begin
                    check(cm_exc == e.exc, e.tag, "commit exc", 64'(cm_exc), 64'(e.exc));
                end
                check(gr_flags == e.gr, e.tag, "gr flags", gr_flags, e.gr);
                check(fr_flags == e.fr, e.tag, "fr flags", fr_flags, e.fr);
            end
        end
    end

    task automatic ld(bit fp, bit [2:0] sz, int dst, int base, bit ui, int idx,
                      logic [31:0] bv, logic [31:0] ov, string tag);
        exp_t e;
        logic [31:0] ea;
        logic [63:0] fl;
        bit am, rm, prop, found;
        @(negedge clk);
        ld_valid = 1; ld_float = fp; ld_size = sz; ld_dst = 6'(dst); ld_base = 6'(base);
        ld_use_idx = ui; ld_idx = 6'(idx); ld_base_val = bv; ld_off_val = ov;
        ea = bv + ov;
        case (sz)
            3'd1: am = ea[0];
            3'd2: am = |ea[1:0];
            3'd3: am = |ea[2:0];
            3'd4: am = |ea[3:0];
            default: am = 0;
        endcase
        rm = (sz == 3'd3) ? dst[0] : (sz == 3'd4) ? (dst[1:0] != 0) : 1'b0;
        fl = fp ? m_fr : m_gr;
        prop = fl[dst == dst ? base : 0] | (ui & fl[idx]);
        if (fp) m_fr[dst] = am | rm | prop; else m_gr[dst] = am | rm | prop;
        e.full = 0;
        if (cfg_valid && cfg_log_en) begin
            found = 0;
            for (int i = 0; i < 4; i++) begin
                if (!found && i < int'(cfg_count) && !m_val[i]) begin
                    found = 1; m_val[i] = 1;
                    m_st[i] = {1'b1, 1'b1, fp, rm, am, sz, 2'(i), 6'(dst)};
                    m_ad[i] = ea;
                end
            end
            e.full = !found;
        end
        e.is_cm = 0; e.go = am | rm | !prop; e.af = am; e.rf = rm; e.exc = 0;
        e.gr = m_gr; e.fr = m_fr; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic cm(bit fp, bit all, int dst, bit lo, bit hi, string tag);
        exp_t e;
        logic [63:0] fl;
        bit was;
        @(negedge clk);
        cm_valid = 1; cm_float = fp; cm_all = all; cm_dst = 6'(dst);
        cm_avail_lo = lo; cm_avail_hi = hi;
        fl = fp ? m_fr : m_gr;
        was = all ? ((hi && |fl[63:32]) || (lo && |fl[31:0])) : fl[dst];
        if (all) begin
            if (lo) fl[31:0] = '0;
            if (hi) fl[63:32] = '0;
        end else fl[dst] = 1'b0;
        if (fp) m_fr = fl; else m_gr = fl;
        e.exc = cfg_valid && cfg_log_en && was;
        if (e.exc)
            for (int i = 0; i < 4; i++)
                if (m_val[i] && m_st[i][13] == fp && (all || m_st[i][5:0] == 6'(dst))) begin
                    m_val[i] = 0; m_st[i] = '0; m_ad[i] = '0;
                end
        e.is_cm = 1; e.go = 0; e.af = 0; e.rf = 0; e.full = 0;
        e.gr = m_gr; e.fr = m_fr; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        cm_valid = 0;
    endtask

    task automatic chk_tab(string tag);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #1;
            check(rd_status == m_st[i], tag, "slot status", 64'(rd_status), 64'(m_st[i]));
            check(rd_addr == m_ad[i], tag, "slot addr", 64'(rd_addr), 64'(m_ad[i]));
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_st[i] = '0; m_ad[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        check(gr_flags == 0 && fr_flags == 0, "R10", "reset flags", gr_flags | fr_flags, 0);
        check(!ld_done && !cm_done && !cm_exc, "R10", "reset outputs", 64'({ld_done, cm_done, cm_exc}), 0);
        chk_tab("R10");

        // R1 address alignment per size
        ld(0, 3'd1, 1, 2, 0, 0, 32'h101, 32'h0, "R1");
        ld(0, 3'd1, 1, 2, 0, 0, 32'h100, 32'h2, "R1");
        ld(0, 3'd2, 2, 9, 0, 0, 32'h100, 32'h2, "R1");
        ld(0, 3'd3, 4, 9, 0, 0, 32'h100, 32'h4, "R1");
        ld(0, 3'd4, 8, 9, 0, 0, 32'h100, 32'h8, "R1");
        ld(0, 3'd4, 12, 9, 0, 0, 32'h108, 32'h8, "R1");
        ld(0, 3'd0, 13, 9, 0, 0, 32'h103, 32'h0, "R1");
        ld(0, 3'd6, 14, 9, 0, 0, 32'h107, 32'h0, "R1");
        // R2 register alignment
        ld(0, 3'd3, 3, 9, 0, 0, 32'h200, 32'h0, "R2");
        ld(0, 3'd4, 6, 9, 0, 0, 32'h200, 32'h0, "R2");
        ld(0, 3'd4, 16, 9, 0, 0, 32'h200, 32'h0, "R2");
        // R5 propagation and suppression
        ld(0, 3'd2, 20, 3, 0, 0, 32'h300, 32'h0, "R5");
        ld(0, 3'd2, 21, 0, 1, 6, 32'h300, 32'h4, "R5");
        ld(0, 3'd2, 20, 0, 0, 6, 32'h300, 32'h4, "R5");
        // R4 fault on flagged source still proceeds
        ld(0, 3'd2, 22, 3, 0, 0, 32'h301, 32'h0, "R4");
        // R3 floating bank is separate
        ld(1, 3'd2, 5, 3, 0, 0, 32'h400, 32'h0, "R3");
        ld(1, 3'd3, 3, 0, 0, 0, 32'h400, 32'h0, "R3");
        ld(1, 3'd2, 7, 3, 0, 0, 32'h400, 32'h0, "R3");
        // R7 commit with logging off: clears, no exception
        cm(0, 0, 20, 0, 0, "R7");
        cm(1, 0, 3, 0, 0, "R7");

        // R6 logging
        cfg_log_en = 1;
        ld(0, 3'd3, 31, 9, 0, 0, 32'h500, 32'h3, "R6");
        ld(1, 3'd2, 9, 0, 0, 0, 32'h600, 32'h8, "R6");
        ld(0, 3'd1, 40, 9, 0, 0, 32'h701, 32'h0, "R6");
        chk_tab("R6");
        ld(0, 3'd0, 33, 9, 0, 0, 32'h7ff, 32'h1, "R6");
        // R9 table full
        ld(0, 3'd2, 34, 9, 0, 0, 32'h802, 32'h0, "R9");
        chk_tab("R9");
        // R7 commit with logging on
        cm(0, 0, 31, 0, 0, "R7");
        chk_tab("R7");
        cm(0, 0, 33, 0, 0, "R7");
        cm(1, 0, 40, 0, 0, "R7");
        chk_tab("R7");
        // R6 lowest free slot reused
        ld(1, 3'd4, 10, 0, 0, 0, 32'h900, 32'h4, "R6");
        chk_tab("R6");
        // R9 count limits allocation
        cm(1, 0, 10, 0, 0, "R9");
        cfg_count = 3'd1;
        ld(0, 3'd2, 35, 9, 0, 0, 32'ha00, 32'h0, "R9");
        chk_tab("R9");
        cfg_count = 3'd4;
        // R8 commit all
        ld(0, 3'd1, 2, 9, 0, 0, 32'hb01, 32'h0, "R8");
        cm(0, 1, 0, 1, 0, "R8");
        chk_tab("R8");
        cm(0, 1, 0, 0, 0, "R8");
        cm(0, 1, 0, 0, 1, "R8");
        chk_tab("R8");
        cm(1, 1, 0, 1, 1, "R8");
        chk_tab("R8");

        @(negedge clk);
        @(negedge clk);
        check(sbq.size() == 0, "R10", "pending results", 64'(sbq.size()), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule